// File: doc/BRIEF.md
# Signed Integer to 23-bit Float Converter

This block turns a stream of signed 16-bit two's-complement samples into a compact 23-bit floating-point word. The word has a 6-bit exponent with an offset of 31, a sign bit, and a 16-bit stored fraction that sits below an implicit leading one. The value it encodes is (-1)^sign × 2^(exponent − 31) × 1.fraction. Every nonzero 16-bit magnitude fits this format exactly, so no rounding takes place.

The converter is fully pipelined and accepts one sample on every clock that has the input strobe high. It has three register stages:
- The first stage takes the sign and the absolute value.
- The second stage finds the leading one.
- The third stage normalises the fraction and packs the fields.

A valid flag runs beside the data through a separate control module. That module also gives the datapath its per-stage load strobes, so the data registers change only for real samples.

Top module: `int2fp23`

## Requirements
- R1: Every sample accepted with `inValid` high appears on `outWord` with `outValid` high exactly 3 clock cycles later. Back-to-back samples leave back-to-back, in their input order. `outValid` is high only for such samples.
- R2: While `rst` is high and in the first cycle after it falls, `outValid` is 0 and `outWord` is all zeros.
- R3: An input of 0 gives an `outWord` of all zeros.
- R4: The fields are packed as follows: exponent in bits [22:17], sign in bit [16], stored fraction in bits [15:0]. A positive input whose highest set bit is at position p (0..14) gives an exponent field of 31 + p and a sign bit of 0.
- R5: A negative input gives sign bit 1. Its exponent and fraction are those of its absolute value.
- R6: The stored fraction holds the bits of the magnitude below its leading one, left-justified so that magnitude bit p−1 lands in bit [15]. All bits below them are 0, so bit [0] is always 0.
- R7: The input −32768 converts exactly to exponent field 46 (31 + 15), sign 1 and fraction 0.
- R8: While `outValid` is low, `outWord` holds its last value, whatever `inData` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | High when `inData` carries a sample |
| inData | input | 16 | Signed two's-complement sample |
| outValid | output | 1 | High when `outWord` carries a converted sample |
| outWord | output | 23 | Packed float: exponent [22:17], sign [16], fraction [15:0] |

## Verification
The stimulus covers zero, the values ±1, the largest positive value, the most negative value, and alternating-bit and sparse single-bit patterns. These separate errors in the zero path, the sign path, the exponent offset and the fraction alignment, and they isolate the one magnitude that needs all 16 bits. A burst of back-to-back random samples with gaps between them checks that latency and ordering hold under full throughput. A final idle stretch with `inData` toggling shows that the output word is frozen while no sample is present.

// File: rtl/fp23_pkg.sv
package fp23_pkg;

  // Load strobes sent from the control path to the datapath stages
  typedef struct packed {
    logic ld1;  // capture sign and magnitude
    logic ld2;  // capture leading-one position
    logic ld3;  // capture packed result
  } i2fStrobe_t;

  localparam int PIPE_DEPTH = 3;

endpackage

// File: rtl/i2f_ctrl.sv
module i2f_ctrl
  import fp23_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output i2fStrobe_t strobe,
  output logic       outValid
);

  logic [PIPE_DEPTH-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[PIPE_DEPTH-2:0], inValid};
  end

  always_comb begin
    strobe.ld1 = inValid;
    strobe.ld2 = vPipe[0];
    strobe.ld3 = vPipe[1];
  end

  assign outValid = vPipe[PIPE_DEPTH-1];

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##3 outValid);

endmodule

// File: rtl/i2f_datapath.sv
module i2f_datapath
  import fp23_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int EXP_W = 6,
  parameter int MAN_W = 16,
  parameter int BIAS  = 31
) (
  input  logic                       clk,
  input  logic                       rst,
  input  i2fStrobe_t                 strobe,
  input  logic [IN_W-1:0]            inData,
  output logic [EXP_W+MAN_W:0]       outWord
);

  localparam int POS_W = $clog2(IN_W);
  localparam int PAD   = MAN_W - IN_W + 1;
  localparam int OUT_W = EXP_W + 1 + MAN_W;

  // Stage 1: sign and magnitude
  logic            s1Sign;
  logic [IN_W-1:0] s1Mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Sign <= 1'b0;
      s1Mag  <= '0;
    end else if (strobe.ld1) begin
      s1Sign <= inData[IN_W-1];
      s1Mag  <= inData[IN_W-1] ? (~inData + 1'b1) : inData;
    end
  end

  // Stage 2: leading-one search
  logic [POS_W-1:0] lodPos;
  logic             lodZero;

  always_comb begin
    lodPos = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (s1Mag[i]) lodPos = POS_W'(i);
    end
    lodZero = (s1Mag == '0);
  end

  logic             s2Sign;
  logic             s2Zero;
  logic [POS_W-1:0] s2Pos;
  logic [IN_W-1:0]  s2Mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2Sign <= 1'b0;
      s2Zero <= 1'b1;
      s2Pos  <= '0;
      s2Mag  <= '0;
    end else if (strobe.ld2) begin
      s2Sign <= s1Sign;
      s2Zero <= lodZero;
      s2Pos  <= lodPos;
      s2Mag  <= s1Mag;
    end
  end

  // Stage 3: normalise and pack
  logic [POS_W-1:0] shiftAmt;
  logic [IN_W-1:0]  normMag;
  logic [MAN_W-1:0] manNext;
  logic [EXP_W-1:0] expNext;
  logic [OUT_W-1:0] wordNext;

  always_comb begin
    shiftAmt = POS_W'(IN_W - 1) - s2Pos;
    normMag  = s2Mag << shiftAmt;
    manNext  = {normMag[IN_W-2:0], {PAD{1'b0}}};
    expNext  = EXP_W'(BIAS) + EXP_W'(s2Pos);
    wordNext = s2Zero ? '0 : {expNext, s2Sign, manNext};
  end

  always_ff @(posedge clk) begin
    if (rst)             outWord <= '0;
    else if (strobe.ld3) outWord <= wordNext;
  end

  // R3
  zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    (outWord[OUT_W-1 -: EXP_W] == '0) |-> (outWord == '0));

  // R4
  exp_range_chk: assert property (@(posedge clk) disable iff (rst)
    (outWord[OUT_W-1 -: EXP_W] != '0) |->
      (outWord[OUT_W-1 -: EXP_W] >= EXP_W'(BIAS) &&
       outWord[OUT_W-1 -: EXP_W] <= EXP_W'(BIAS + IN_W - 1)));

  // R5
  sign_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    outWord[MAN_W] |-> (outWord[OUT_W-1 -: EXP_W] != '0));

  // R6
  man_pad_chk: assert property (@(posedge clk) disable iff (rst)
    outWord[PAD-1:0] == '0);

endmodule

// File: rtl/int2fp23.sv
module int2fp23
  import fp23_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int EXP_W = 6,
  parameter int MAN_W = 16,
  parameter int BIAS  = 31
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic [IN_W-1:0]        inData,
  output logic                   outValid,
  output logic [EXP_W+MAN_W:0]   outWord
);

  i2fStrobe_t strobe;

  i2f_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  i2f_datapath #(
    .IN_W  (IN_W),
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .BIAS  (BIAS)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inData  (inData),
    .outWord (outWord)
  );

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outWord));

endmodule

// File: tb/int2fp23_tb.sv
module int2fp23_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        outValid;
  logic [22:0] outWord;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [22:0] expQ[$];
  int          dueQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int2fp23 u_dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outWord  (outWord)
  );

  function automatic logic [22:0] refConv(input logic [15:0] x);
    int v, mag, p, man;
    bit s;
    v = int'($signed(x));
    if (v == 0) return 23'd0;
    s   = (v < 0);
    mag = s ? -v : v;
    p = 0;
    for (int i = 0; i < 16; i++) if (mag >= (1 << i)) p = i;
    man = ((mag - (1 << p)) << (16 - p)) & 32'hFFFF;
    return {6'(31 + p), s, man[15:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one sample; the caller sits just after a rising edge.
  task automatic send(input logic [15:0] x, input string tag);
    inValid = 1'b1;
    inData  = x;
    expQ.push_back(refConv(x));
    dueQ.push_back(cyc + 3);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      inData = 16'($urandom);
      @(posedge clk); #1;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected output", 32'(outWord), 0);
      end else begin
        logic [22:0] e;
        int d;
        string t;
        e = expQ.pop_front();
        d = dueQ.pop_front();
        t = tagQ.pop_front();
        check(outWord == e, t, 32'(outWord), 32'(e));
        check(cyc == d, "R1 latency", 32'(cyc), 32'(d));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 0);
    finishRun();
  end

  initial begin
    logic [22:0] held;
    repeat (4) @(posedge clk);
    #1;
    // R2: state during reset
    @(negedge clk);
    check(outValid == 1'b0, "R2 valid in reset", 32'(outValid), 0);
    check(outWord == '0, "R2 word in reset", 32'(outWord), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R2 valid after reset", 32'(outValid), 0);
    check(outWord == '0, "R2 word after reset", 32'(outWord), 0);
    @(posedge clk); #1;

    send(16'h0000, "R3 zero");
    send(16'h0001, "R4 one");
    send(16'hFFFF, "R5 minus one");
    idle(2);
    send(16'h7FFF, "R4 max positive");
    send(16'h8000, "R7 most negative");
    send(16'h5555, "R6 alternating");
    send(16'hEDCC, "R5 negative pattern");
    send(16'h0100, "R6 single bit");
    send(16'h4000, "R4 top positive bit");
    idle(5);

    // R1: back-to-back burst with occasional gaps
    for (int i = 0; i < 300; i++) begin
      send(16'($urandom), "R1 R4 R5 R6 random");
      if (i % 37 == 0) idle(1);
    end
    idle(6);
    check(expQ.size() == 0, "R1 outstanding", 32'(expQ.size()), 0);

    // R8: output frozen while idle and input toggles
    @(negedge clk);
    held = outWord;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      inData = 16'($urandom);
      @(negedge clk);
      check(outWord == held && !outValid, "R8 hold", 32'(outWord), 32'(held));
    end
    finishRun();
  end

endmodule